// File: doc/BRIEF.md
# UART Channel Character Queue Pair with Trigger Interrupts

This block holds the two character queues of one serial channel. The transmit queue is written by the host bus and drained by the transmit shift register. The receive queue is filled by the receive shift register and read by the host bus. Each queue is 64 entries deep. Each queue reports its level, its empty and full state, and sticky flags for lost pushes and lost pops.

A single control-byte write port configures the block. The fields are: a gate bit, two one-shot queue-clear bits, a ready-mode bit and two 2-bit trigger selects. From the queue levels and the selected thresholds the block derives the receive and transmit interrupt requests. It also drives two ready strobes. In normal mode they follow queue occupancy. In transfer-engine mode they follow the threshold and full state.

Top module: `uart_fifo_pair`

## Requirements
- R1: While `rst` is high and on the first cycle after it drops, both levels are 0, both empty flags are 1, both full flags are 0, all four sticky flags are 0, `rx_irq`=0, `tx_irq`=1, `rxrdy`=0 and `txrdy`=1.
- R2: Each queue returns characters in push order. The head character is visible on its read-data output while the queue is not empty. The level counts 0 to 64, and the full flag is 1 exactly at 64.
- R3: A push to a full queue, unless a pop is accepted in the same cycle, is dropped and sets that queue's overflow flag. A pop from an empty queue is dropped and sets its underflow flag. Both flags stay set until `rst`.
- R4: The control byte has bit 0 as the gate, bit 1 as receive clear and bit 2 as transmit clear. A write with bit 0 and bit 1 set empties the receive queue on the next edge. A write with bit 0 and bit 2 set does the same for the transmit queue. Without bit 0 the clear bits do nothing. A clear acts only on the write cycle, leaves the other queue and the sticky flags unchanged, and the queue accepts pushes normally afterwards.
- R5: Bits 7:6 (receive select) and 5:4 (transmit select) are captured only on a control write while `ext_en`=1. Other writes leave the selects unchanged. Until the first capture, both thresholds are 1 character.
- R6: Receive select codes 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60.
- R7: Transmit select codes 0, 1, 2 and 3 give thresholds of 8, 16, 32 and 56.
- R8: `rx_irq` is 1 exactly when the receive level is at or above the receive threshold.
- R9: Suppose the transmit level has been above the transmit threshold since the queue was last empty. Then `tx_irq` is 1 once the level drops below the threshold. Otherwise `tx_irq` is 1 only while the transmit queue is empty.
- R10: Control bit 3 is taken on every control write: 0 selects normal mode, 1 selects transfer-engine mode. In normal mode `rxrdy` = receive queue not empty and `txrdy` = transmit queue empty.
- R11: In transfer-engine mode `rxrdy` = (receive level at or above threshold) or `rx_timeout`, and `txrdy` = transmit queue not full.
- R12: A push and a pop on the same queue in the same cycle both take effect when the queue is neither empty nor full, and the level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ext_en | input | 1 | Permits capture of the trigger selects |
| rx_timeout | input | 1 | Pending receive timeout, used in transfer-engine mode |
| tx_push | input | 1 | Host writes a transmit character |
| tx_wdata | input | 8 | Transmit character in |
| tx_pop | input | 1 | Shift register takes a transmit character |
| tx_rdata | output | 8 | Head of transmit queue |
| tx_level | output | 7 | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_ovf | output | 1 | Sticky: transmit push dropped |
| tx_unf | output | 1 | Sticky: transmit pop dropped |
| rx_push | input | 1 | Shift register delivers a received character |
| rx_wdata | input | 8 | Received character in |
| rx_pop | input | 1 | Host reads a received character |
| rx_rdata | output | 8 | Head of receive queue |
| rx_level | output | 7 | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_ovf | output | 1 | Sticky: receive push dropped |
| rx_unf | output | 1 | Sticky: receive pop dropped |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| txrdy | output | 1 | Transmit ready strobe |
| rxrdy | output | 1 | Receive ready strobe |

## Verification
A corrupted level counter or pointer shows up one edge later as a wrong level. It also shows up as a character returned out of order, or as an empty or full flag out of step with the number of pushes. A wrong threshold register or a stale transmit arming flag shows up at `rx_irq` or `tx_irq` the first cycle the level crosses the selected threshold. That is why each table entry is stepped through one character below, at and past its threshold. A wrong mode register changes `rxrdy` or `txrdy` on the cycle right after the control write, while queue contents tell the two modes apart.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 64;
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1);

    typedef logic [LVL_W-1:0] lvl_t;

    // Control byte layout, most significant field first.
    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       xfer;
        logic       tx_clr;
        logic       rx_clr;
        logic       gate;
    } ctl_word_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_XFER   = 1'b1
    } rdy_mode_e;

    function automatic lvl_t rx_thresh(input logic [1:0] sel);
        case (sel)
            2'd0:    return lvl_t'(8);
            2'd1:    return lvl_t'(16);
            2'd2:    return lvl_t'(56);
            default: return lvl_t'(60);
        endcase
    endfunction

    function automatic lvl_t tx_thresh(input logic [1:0] sel);
        case (sel)
            2'd0:    return lvl_t'(8);
            2'd1:    return lvl_t'(16);
            2'd2:    return lvl_t'(32);
            default: return lvl_t'(56);
        endcase
    endfunction

endpackage

// File: rtl/ufp_queue.sv
module ufp_queue #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              ovf,
    output logic              unf
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cnt;
    logic              pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == LVL_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign level   = cnt;
    assign rdata   = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (!clr) begin
            if (push && !push_ok) ovf <= 1'b1;
            if (pop && !pop_ok)   unf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) store[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/ufp_ctl.sv
module ufp_ctl
    import ufp_pkg::*;
#(
    parameter int unsigned LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       wdata,
    input  logic             ext_en,
    output logic             rx_clr,
    output logic             tx_clr,
    output rdy_mode_e        mode,
    output logic [LVL_W-1:0] rx_trig,
    output logic [LVL_W-1:0] tx_trig
);

    ctl_word_t  word;
    logic [1:0] rx_sel_q, tx_sel_q;
    logic       sel_valid_q;

    assign word   = ctl_word_t'(wdata);
    assign rx_clr = we && word.gate && word.rx_clr;
    assign tx_clr = we && word.gate && word.tx_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MODE_NORMAL;
            rx_sel_q    <= '0;
            tx_sel_q    <= '0;
            sel_valid_q <= 1'b0;
        end else if (we) begin
            mode <= word.xfer ? MODE_XFER : MODE_NORMAL;
            if (ext_en) begin
                rx_sel_q    <= word.rx_sel;
                tx_sel_q    <= word.tx_sel;
                sel_valid_q <= 1'b1;
            end
        end
    end

    assign rx_trig = sel_valid_q ? LVL_W'(rx_thresh(rx_sel_q)) : LVL_W'(1);
    assign tx_trig = sel_valid_q ? LVL_W'(tx_thresh(tx_sel_q)) : LVL_W'(1);

endmodule

// File: rtl/ufp_tx_arm.sv
module ufp_tx_arm #(
    parameter int unsigned LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             irq
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (level == '0) begin
            armed_q <= 1'b0;
        end else if (level > trig) begin
            armed_q <= 1'b1;
        end
    end

    assign irq = armed_q ? (level < trig) : (level == '0);

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import ufp_pkg::*;
#(
    parameter int unsigned DATA_W = ufp_pkg::DATA_W,
    parameter int unsigned DEPTH  = ufp_pkg::DEPTH,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              ext_en,
    input  logic              rx_timeout,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [LVL_W-1:0]  tx_level,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_ovf,
    output logic              tx_unf,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              rx_unf,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              txrdy,
    output logic              rxrdy
);

    logic             rx_clr, tx_clr;
    rdy_mode_e        rdy_mode;
    logic [LVL_W-1:0] rx_trig, tx_trig;

    ufp_ctl #(.LVL_W(LVL_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .ext_en  (ext_en),
        .rx_clr  (rx_clr),
        .tx_clr  (tx_clr),
        .mode    (rdy_mode),
        .rx_trig (rx_trig),
        .tx_trig (tx_trig)
    );

    ufp_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .level (tx_level),
        .empty (tx_empty),
        .full  (tx_full),
        .ovf   (tx_ovf),
        .unf   (tx_unf)
    );

    ufp_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .level (rx_level),
        .empty (rx_empty),
        .full  (rx_full),
        .ovf   (rx_ovf),
        .unf   (rx_unf)
    );

    ufp_tx_arm #(.LVL_W(LVL_W)) u_txarm (
        .clk   (clk),
        .rst   (rst),
        .level (tx_level),
        .trig  (tx_trig),
        .irq   (tx_irq)
    );

    assign rx_irq = (rx_level >= rx_trig);

    always_comb begin
        case (rdy_mode)
            MODE_XFER: begin
                rxrdy = rx_irq || rx_timeout;
                txrdy = !tx_full;
            end
            default: begin
                rxrdy = !rx_empty;
                txrdy = tx_empty;
            end
        endcase
    end

endmodule

// File: rtl/ufp_chk.sv
module ufp_chk
    import ufp_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_we,
    input logic [7:0]       ctl_wdata,
    input logic             tx_push,
    input logic             tx_pop,
    input logic [LVL_W-1:0] tx_level,
    input logic             tx_full,
    input logic             tx_ovf,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             rx_unf,
    input logic             txrdy,
    input logic             rxrdy,
    input rdy_mode_e        mode
);

    logic rx_wipe, tx_wipe;
    assign rx_wipe = ctl_we && ctl_wdata[0] && ctl_wdata[1];
    assign tx_wipe = ctl_we && ctl_wdata[0] && ctl_wdata[2];

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(DEPTH) && tx_level <= LVL_W'(DEPTH)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        tx_full && tx_push && !tx_pop && !tx_wipe |=> tx_level == LVL_W'(DEPTH) && tx_ovf); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        rx_empty && rx_pop && !rx_push |=> rx_level == '0 && rx_unf); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |=> tx_ovf); // R3

    AST_RX_WIPE: assert property (@(posedge clk) disable iff (rst)
        rx_wipe |=> rx_level == '0); // R4

    AST_WIPE_GATED: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_wdata[0] && !rx_push && !rx_pop |=> $stable(rx_level)); // R4

    AST_NORMAL_RXRDY: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_NORMAL |-> rxrdy == !rx_empty); // R10

    AST_XFER_TXRDY: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_XFER |-> txrdy == !tx_full); // R11

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_empty && !rx_full && rx_push && rx_pop && !rx_wipe |=> $stable(rx_level)); // R12

endmodule

bind uart_fifo_pair ufp_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .tx_push   (tx_push),
    .tx_pop    (tx_pop),
    .tx_level  (tx_level),
    .tx_full   (tx_full),
    .tx_ovf    (tx_ovf),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rx_level  (rx_level),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full),
    .rx_unf    (rx_unf),
    .txrdy     (txrdy),
    .rxrdy     (rxrdy),
    .mode      (rdy_mode)
);

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       ext_en = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata;
    logic [6:0] tx_level, rx_level;
    logic       tx_empty, tx_full, tx_ovf, tx_unf;
    logic       rx_empty, rx_full, rx_ovf, rx_unf;
    logic       tx_irq, rx_irq, txrdy, rxrdy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_fifo_pair i_uart_fifo_pair (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ext_en(ext_en),
        .rx_timeout(rx_timeout),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_level(tx_level), .tx_empty(tx_empty), .tx_full(tx_full), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .txrdy(txrdy), .rxrdy(rxrdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rx_t(input int s);
        case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
    endfunction

    function automatic int tx_t(input int s);
        case (s) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    // All tasks start and end at a falling edge.
    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_wdata = d; @(negedge clk); tx_push = 1'b0;
    endtask
    task automatic pop_tx();
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    endtask
    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_wdata = d; @(negedge clk); rx_push = 1'b0;
    endtask
    task automatic pop_rx();
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask
    task automatic ctl_wr(input logic [7:0] d, input logic ext);
        ctl_we = 1'b1; ctl_wdata = d; ext_en = ext; @(negedge clk);
        ctl_we = 1'b0; ext_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 empties", {rx_empty, tx_empty}, 3);
        chk("R1 fulls", {rx_full, tx_full}, 0);
        chk("R1 sticky", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        chk("R1 irqs", {rx_irq, tx_irq}, 1);
        chk("R1 ready", {rxrdy, txrdy}, 1);
    endtask

    task automatic t_order();
        push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
        chk("R2 rx level", rx_level, 3);
        chk("R2 rx head", rx_rdata, 8'hA1);
        chk("R10 rxrdy normal", rxrdy, 1);
        pop_rx();
        chk("R2 rx head 2", rx_rdata, 8'hB2);
        pop_rx();
        chk("R2 rx head 3", rx_rdata, 8'hC3);
        pop_rx();
        chk("R2 rx empty", {rx_empty, rx_level}, {1'b1, 7'd0});
        chk("R10 rxrdy empty", rxrdy, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 64; i++) push_tx(8'(i + 16));
        chk("R2 tx full", {tx_full, tx_level}, {1'b1, 7'd64});
        chk("R10 txrdy not empty", txrdy, 0);
        chk("R3 no ovf yet", tx_ovf, 0);
        push_tx(8'hEE);
        chk("R3 full push dropped", tx_level, 64);
        chk("R3 tx ovf", tx_ovf, 1);
        for (int i = 0; i < 64; i++) begin
            chk("R2 tx order", tx_rdata, 8'(i + 16));
            pop_tx();
        end
        chk("R2 tx drained", {tx_empty, tx_unf}, 2);
        pop_tx();
        chk("R3 tx unf", {tx_unf, tx_level}, {1'b1, 7'd0});
        pop_rx();
        chk("R3 rx unf", {rx_unf, rx_ovf, rx_level}, {1'b1, 1'b0, 7'd0});
        pop_tx();
        chk("R3 tx ovf sticky", tx_ovf, 1);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 5; i++) push_rx(8'(i));
        push_tx(8'h71); push_tx(8'h72);
        ctl_wr(8'h02, 1'b0);
        chk("R4 ungated rx clear", rx_level, 5);
        ctl_wr(8'h06, 1'b0);
        chk("R4 ungated both", {rx_level, tx_level}, {7'd5, 7'd2});
        ctl_wr(8'h03, 1'b0);
        chk("R4 rx cleared", {rx_empty, rx_level}, {1'b1, 7'd0});
        chk("R4 tx untouched", tx_level, 2);
        chk("R4 sticky kept", {tx_ovf, rx_unf}, 3);
        push_rx(8'h5A);
        chk("R4 one-shot push", {rx_level, rx_rdata}, {7'd1, 8'h5A});
        ctl_wr(8'h05, 1'b0);
        chk("R4 tx cleared", {tx_level, rx_level}, {7'd0, 7'd1});
    endtask

    task automatic t_default_trig();
        ctl_wr(8'hF3, 1'b0);
        chk("R5 cleared", rx_level, 0);
        chk("R5 rx irq at 0", rx_irq, 0);
        push_rx(8'h01);
        chk("R5 default rx trig 1", rx_irq, 1);
        push_tx(8'h01); push_tx(8'h02);
        chk("R9 default armed", tx_irq, 0);
        pop_tx();
        chk("R9 level 1 not below", tx_irq, 0);
        pop_tx();
        chk("R9 empty irq", tx_irq, 1);
        ctl_wr(8'h03, 1'b0);
    endtask

    task automatic t_rx_table();
        for (int s = 0; s < 4; s++) begin
            int t = rx_t(s);
            ctl_wr({2'(s), 6'b000011}, 1'b1);
            for (int i = 0; i < t - 1; i++) push_rx(8'(i));
            chk("R8 below trig", rx_irq, 0);
            push_rx(8'hFF);
            chk("R6 at trig", {rx_irq, rx_level}, {1'b1, 7'(t)});
            pop_rx();
            chk("R8 back below", rx_irq, 0);
        end
    endtask

    task automatic t_tx_table();
        for (int s = 0; s < 4; s++) begin
            int t = tx_t(s);
            ctl_wr({2'b00, 2'(s), 4'b0101}, 1'b1);
            for (int i = 0; i <= t; i++) push_tx(8'(i));
            chk("R9 above trig", tx_irq, 0);
            pop_tx();
            chk("R7 at trig", {tx_irq, tx_level}, {1'b0, 7'(t)});
            pop_tx();
            chk("R7 below trig", tx_irq, 1);
            ctl_wr({2'b00, 2'(s), 4'b0101}, 1'b1);
            for (int i = 0; i < t - 1; i++) push_tx(8'(i));
            chk("R9 never exceeded", tx_irq, 0);
            for (int i = 0; i < t - 1; i++) pop_tx();
            chk("R9 empty after low refill", {tx_irq, tx_empty}, 3);
        end
    endtask

    task automatic t_simul();
        ctl_wr(8'h03, 1'b0);
        push_rx(8'h11); push_rx(8'h22);
        rx_push = 1'b1; rx_wdata = 8'h33; rx_pop = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R12 level kept", rx_level, 2);
        chk("R12 head advanced", rx_rdata, 8'h22);
        pop_rx();
        chk("R12 pushed kept", rx_rdata, 8'h33);
        pop_rx();
        rx_push = 1'b1; rx_wdata = 8'h44; rx_pop = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R3 pop on empty with push", {rx_level, rx_rdata}, {7'd1, 8'h44});
    endtask

    task automatic t_xfer();
        ctl_wr(8'h0F, 1'b1);
        chk("R11 txrdy empty", txrdy, 1);
        push_tx(8'h00);
        chk("R11 txrdy not full", txrdy, 1);
        for (int i = 1; i < 64; i++) push_tx(8'(i));
        chk("R11 txrdy full", txrdy, 0);
        push_rx(8'h1); push_rx(8'h2); push_rx(8'h3);
        chk("R11 rxrdy below trig", rxrdy, 0);
        rx_timeout = 1'b1; #1;
        chk("R11 rxrdy timeout", rxrdy, 1);
        @(negedge clk); rx_timeout = 1'b0; #1;
        chk("R11 rxrdy timeout gone", rxrdy, 0);
        @(negedge clk);
        for (int i = 0; i < 5; i++) push_rx(8'(i));
        chk("R11 rxrdy at trig", rxrdy, 1);
        ctl_wr(8'h00, 1'b0);
        chk("R10 normal again", {rxrdy, txrdy}, 2);
        chk("R10 levels kept", {rx_level, tx_level}, {7'd8, 7'd64});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_clear();
        t_default_trig();
        t_rx_table();
        t_tx_table();
        t_simul();
        t_xfer();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule